// File: doc/BRIEF.md
# Multi-Core Inter-Processor Interrupt Mailbox

This block lets up to sixteen cores, grouped as four nodes of four cores each, signal one another through memory-mapped registers. Every core owns a 32-bit pending word, a 32-bit stored enable word, a write-only port that raises pending bits, a write-only port that lowers them, and a 32-byte mailbox for passing a message along with the interrupt. Each core has one interrupt output line.

A sender writes its message into the target's mailbox and then writes the target's raise port. That write sets the target's interrupt line. The target reads the mailbox and then writes its own lower port. Its interrupt line drops only once no pending bit remains. The enable word is kept for software to read back but does not mask the line.

Requests arrive on a single-cycle register bus. A request is an address, a size flag, a write flag and 64 bits of write data. Writes take effect at the edge that accepts them. Read data comes back one cycle later together with a valid strobe. An error strobe appears in the same cycle for any request that is misaligned or that misses the register map.

Top module: `ipi_mailbox_ctrl`

## Requirements
- R1: The target core id is {reqAddr[45:44], reqAddr[9:8]}, i.e. core-in-node + 4*node. Address bits 43..10 are ignored. The register offset is reqAddr[7:0].
- R2: A read at offset 0x00 returns the core's pending word, zero-extended to 64 bits.
- R3: A write at offset 0x08 ORs wdata[31:0] into the pending word and sets that core's irqOut bit from the next cycle. This holds even when the data is zero.
- R4: A write at offset 0x0C ANDs the pending word with ~wdata[31:0]. The core's irqOut bit clears only if the resulting pending word is zero; otherwise it stays high.
- R5: Reads at offsets 0x08 and 0x0C return zero. Writes at offset 0x00 change nothing.
- R6: A write at offset 0x04 stores wdata[31:0] as the enable word, and a read there returns it. The enable word never masks irqOut.
- R7: Offsets 0x20..0x3F address the mailbox, byte position = offset - 0x20. A 4-byte access uses data bits [31:0]. An 8-byte access is little-endian: the lower address holds bits [31:0].
- R8: reqSize 0 means 4 bytes and 1 means 8 bytes. An offset not aligned to the size raises rspErr one cycle later, changes no state, and reads as zero.
- R9: An aligned offset outside {0x00, 0x04, 0x08, 0x0C, 0x20..0x3F} raises rspErr one cycle later. A read there returns zero and a write there changes nothing. Legal accesses leave rspErr low.
- R10: While reset is held low, every pending word, enable word and mailbox byte clears, and every irqOut bit is zero.
- R11: rspValid pulses, with rspRdata, exactly one cycle after each read request. Write requests and idle cycles give no rspValid.
- R12: An access to one core never changes the pending word, enable word, mailbox or irqOut bit of any other core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 46 | Byte address: node, core and offset |
| reqSize | input | 1 | 0 = 4-byte, 1 = 8-byte access |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after a read |
| rspRdata | output | 64 | Read data |
| rspErr | output | 1 | Misaligned or unmapped request, one cycle after it |
| irqOut | output | 16 | One interrupt line per core, index = core id |

## Verification
If a pending word is corrupted, the fault shows up in two places. A read of offset 0x00 returns the wrong value in the cycle after the read. A lower-port write that should leave bits pending would drop irqOut in the cycle after that write, or fail to drop it. A wrong core-id decode moves effects onto a neighbouring core. Every irqOut bit is compared on each step, so such a fault shows up in the cycle after the write, and a later read of the untouched core exposes leaked mailbox data. A broken alignment or map check shows up as a missing or spurious rspErr, or as a mailbox word that changes when it should not.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int NODE_BITS = 2;
  localparam int CORE_BITS = 2;
  localparam int ID_W = NODE_BITS + CORE_BITS;
  localparam int NUM_CORES = 1 << ID_W;
  localparam int STAT_W = 32;
  localparam int DATA_W = 64;
  localparam int MBOX_BYTES = 32;
  localparam int MBOX_WORDS = MBOX_BYTES / 4;
  localparam int WSEL_W = $clog2(MBOX_WORDS);
  localparam int OFF_W = 8;

  localparam logic [OFF_W-1:0] OFF_PEND = 8'h00;
  localparam logic [OFF_W-1:0] OFF_ENAB = 8'h04;
  localparam logic [OFF_W-1:0] OFF_RAISE = 8'h08;
  localparam logic [OFF_W-1:0] OFF_LOWER = 8'h0C;
  localparam logic [OFF_W-1:0] OFF_MBOX = 8'h20;

  typedef struct packed {
    logic [ID_W-1:0]   coreId;
    logic [WSEL_W-1:0] word;
    logic              wide;
    logic              wrEnable;
    logic              wrRaise;
    logic              wrLower;
    logic              wrMbox;
    logic              rdLoad;
    logic              rdPend;
    logic              rdEnable;
    logic              rdMbox;
  } ctlStrobes_t;
endpackage

// File: rtl/ipi_mbox_ctrl.sv
module ipi_mbox_ctrl
  import ipi_mbox_pkg::*;
#(
  parameter int ADDR_W = 46,
  parameter int NODE_LSB = 44,
  parameter int CORE_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSize,
  output ctlStrobes_t       strobes,
  output logic              rspValid,
  output logic              rspErr
);
  logic [OFF_W-1:0] offset;
  logic             misaligned;
  logic             hitPend, hitEnab, hitRaise, hitLower, hitMbox;
  logic             mapped, bad, good;

  assign offset = reqAddr[OFF_W-1:0];
  assign misaligned = reqSize ? (offset[2:0] != 3'd0) : (offset[1:0] != 2'd0);

  always_comb begin
    hitPend  = (offset == OFF_PEND);
    hitEnab  = (offset == OFF_ENAB);
    hitRaise = (offset == OFF_RAISE);
    hitLower = (offset == OFF_LOWER);
    hitMbox  = (offset >= OFF_MBOX) && (offset < OFF_MBOX + OFF_W'(MBOX_BYTES));
  end

  assign mapped = hitPend | hitEnab | hitRaise | hitLower | hitMbox;
  assign bad = misaligned | ~mapped;
  assign good = reqValid & ~bad;

  always_comb begin
    strobes = '0;
    strobes.coreId = {reqAddr[NODE_LSB +: NODE_BITS], reqAddr[CORE_LSB +: CORE_BITS]};
    strobes.word = offset[2 +: WSEL_W];
    strobes.wide = reqSize;
    strobes.wrEnable = good & reqWrite & hitEnab;
    strobes.wrRaise = good & reqWrite & hitRaise;
    strobes.wrLower = good & reqWrite & hitLower;
    strobes.wrMbox = good & reqWrite & hitMbox;
    strobes.rdLoad = reqValid & ~reqWrite;
    strobes.rdPend = good & ~reqWrite & hitPend;
    strobes.rdEnable = good & ~reqWrite & hitEnab;
    strobes.rdMbox = good & ~reqWrite & hitMbox;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr <= 1'b0;
    end else begin
      rspValid <= reqValid & ~reqWrite;
      rspErr <= reqValid & bad;
    end
  end
endmodule

// File: rtl/ipi_mbox_datapath.sv
module ipi_mbox_datapath
  import ipi_mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_CORES-1:0] irqOut
);
  logic [STAT_W-1:0] pendQ [NUM_CORES];
  logic [STAT_W-1:0] enabQ [NUM_CORES];
  logic [31:0]       mboxQ [NUM_CORES][MBOX_WORDS];
  logic [NUM_CORES-1:0] irqQ;

  logic [WSEL_W-1:0] wordLo, wordHi;
  assign wordLo = strobes.word;
  assign wordHi = {strobes.word[WSEL_W-1:1], 1'b1};

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic sel;
    logic [STAT_W-1:0] lowered;
    assign sel = (strobes.coreId == ID_W'(c));
    assign lowered = pendQ[c] & ~wdata[STAT_W-1:0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[c] <= '0;
        irqQ[c] <= 1'b0;
      end else if (sel && strobes.wrRaise) begin
        pendQ[c] <= pendQ[c] | wdata[STAT_W-1:0];
        irqQ[c] <= 1'b1;
      end else if (sel && strobes.wrLower) begin
        pendQ[c] <= lowered;
        if (lowered == '0) irqQ[c] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) enabQ[c] <= '0;
      else if (sel && strobes.wrEnable) enabQ[c] <= wdata[STAT_W-1:0];
    end

    for (genvar w = 0; w < MBOX_WORDS; w++) begin : g_word
      logic hitLo, hitHi;
      assign hitLo = sel && strobes.wrMbox && (wordLo == WSEL_W'(w));
      assign hitHi = sel && strobes.wrMbox && strobes.wide && (wordHi == WSEL_W'(w));
      always_ff @(posedge clk) begin
        if (!rstN) mboxQ[c][w] <= '0;
        else if (hitHi) mboxQ[c][w] <= wdata[63:32];
        else if (hitLo) mboxQ[c][w] <= wdata[31:0];
      end
    end
  end

  logic [DATA_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    if (strobes.rdPend) rdNext = DATA_W'(pendQ[strobes.coreId]);
    else if (strobes.rdEnable) rdNext = DATA_W'(enabQ[strobes.coreId]);
    else if (strobes.rdMbox) begin
      if (strobes.wide) rdNext = {mboxQ[strobes.coreId][wordHi], mboxQ[strobes.coreId][wordLo]};
      else rdNext = DATA_W'(mboxQ[strobes.coreId][wordLo]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobes.rdLoad) rdData <= rdNext;
  end

  assign irqOut = irqQ;
endmodule

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl
  import ipi_mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [45:0]          reqAddr,
  input  logic                 reqSize,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspRdata,
  output logic                 rspErr,
  output logic [NUM_CORES-1:0] irqOut
);
  ctlStrobes_t strobes;

  ipi_mbox_ctrl #(.ADDR_W(46), .NODE_LSB(44), .CORE_LSB(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .strobes(strobes),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  ipi_mbox_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(reqWdata),
    .rdData(rspRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/ipi_mbox_chk.sv
module ipi_mbox_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [45:0] reqAddr,
  input logic        reqSize,
  input logic        rspValid,
  input logic        rspErr,
  input logic [15:0] irqOut
);
  logic [3:0] tgt;
  logic       raiseReq, unaligned;
  assign tgt = {reqAddr[45:44], reqAddr[9:8]};
  assign raiseReq = reqValid && reqWrite && (reqAddr[7:0] == 8'h08);
  assign unaligned = reqSize ? (reqAddr[2:0] != 3'd0) : (reqAddr[1:0] != 2'd0);

  // R3
  raise_sets_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    raiseReq |=> irqOut[$past(tgt)]);

  // R3
  line_rises_only_on_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(irqOut & ~$past(irqOut))) |-> $past(raiseReq));

  // R11
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite));

  // R8
  misalign_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && unaligned) |=> rspErr);

  // R9
  err_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> $past(reqValid));
endmodule

bind ipi_mailbox_ctrl ipi_mbox_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqSize(reqSize), .rspValid(rspValid),
  .rspErr(rspErr), .irqOut(irqOut)
);

// File: tb/sim_ipi_mailbox_ctrl.sv
module sim_ipi_mailbox_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [45:0] reqAddr = '0;
  logic        reqSize = 1'b0;
  logic [63:0] reqWdata = '0;
  logic        rspValid;
  logic [63:0] rspRdata;
  logic        rspErr;
  logic [15:0] irqOut;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  ipi_mailbox_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr), .irqOut(irqOut)
  );

  logic [63:0] lastData;
  logic        lastValid, lastErr;

  function automatic logic [45:0] mkAddr(int node, int core, logic [7:0] off);
    return (46'(node) << 44) | (46'(core) << 8) | 46'(off);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic wr, logic [45:0] a, logic sz, logic [63:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = d;
    @(posedge clk);
    #1;
    lastData = rspRdata; lastValid = rspValid; lastErr = rspErr;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic tReset();
    chk("R10 irq after reset", 64'(irqOut), 64'h0);
    access(1'b0, mkAddr(0, 0, 8'h00), 1'b0, '0);
    chk("R10 pending core0", lastData, 64'h0);
    access(1'b0, mkAddr(3, 3, 8'h38), 1'b1, '0);
    chk("R10 mailbox core15", lastData, 64'h0);
    access(1'b0, mkAddr(2, 1, 8'h04), 1'b0, '0);
    chk("R10 enable core9", lastData, 64'h0);
  endtask

  task automatic tRaise();
    access(1'b1, mkAddr(1, 1, 8'h08), 1'b0, 64'h3);
    chk("R3 raise core5 irq", 64'(irqOut), 64'h0020);
    access(1'b0, mkAddr(1, 1, 8'h00), 1'b0, '0);
    chk("R2 pending core5", lastData, 64'h3);
    access(1'b1, mkAddr(1, 3, 8'h08), 1'b0, 64'h0);
    chk("R3 zero raise core7 irq", 64'(irqOut), 64'h00A0);
  endtask

  task automatic tLower();
    access(1'b1, mkAddr(1, 1, 8'h0C), 1'b0, 64'h1);
    chk("R4 partial lower keeps irq", 64'(irqOut), 64'h00A0);
    access(1'b0, mkAddr(1, 1, 8'h00), 1'b0, '0);
    chk("R4 pending after partial lower", lastData, 64'h2);
    access(1'b1, mkAddr(1, 1, 8'h0C), 1'b0, 64'h2);
    chk("R4 full lower drops irq", 64'(irqOut), 64'h0080);
    access(1'b1, mkAddr(1, 3, 8'h0C), 1'b0, 64'h0);
    chk("R4 lower on empty drops irq", 64'(irqOut), 64'h0);
  endtask

  task automatic tWriteOnly();
    access(1'b1, mkAddr(0, 2, 8'h08), 1'b0, 64'hF0);
    access(1'b0, mkAddr(0, 2, 8'h08), 1'b0, '0);
    chk("R5 raise port reads zero", lastData, 64'h0);
    access(1'b0, mkAddr(0, 2, 8'h0C), 1'b0, '0);
    chk("R5 lower port reads zero", lastData, 64'h0);
    access(1'b1, mkAddr(0, 2, 8'h00), 1'b0, 64'hFFFF);
    access(1'b0, mkAddr(0, 2, 8'h00), 1'b0, '0);
    chk("R5 pending write ignored", lastData, 64'hF0);
    chk("R5 irq unchanged", 64'(irqOut), 64'h0004);
    access(1'b1, mkAddr(0, 2, 8'h0C), 1'b0, 64'hF0);
  endtask

  task automatic tEnable();
    access(1'b1, mkAddr(0, 3, 8'h04), 1'b0, 64'h0);
    access(1'b1, mkAddr(0, 3, 8'h08), 1'b0, 64'h1);
    chk("R6 zero enable does not mask", 64'(irqOut), 64'h0008);
    access(1'b1, mkAddr(0, 3, 8'h04), 1'b0, 64'h1234ABCD);
    access(1'b0, mkAddr(0, 3, 8'h04), 1'b0, '0);
    chk("R6 enable readback", lastData, 64'h1234ABCD);
    access(1'b1, mkAddr(0, 3, 8'h0C), 1'b0, 64'h1);
    chk("R6 irq follows pending only", 64'(irqOut), 64'h0);
  endtask

  task automatic tMailbox();
    access(1'b1, mkAddr(3, 0, 8'h28), 1'b1, 64'h1122334455667788);
    access(1'b0, mkAddr(3, 0, 8'h28), 1'b0, '0);
    chk("R7 low word", lastData, 64'h55667788);
    access(1'b0, mkAddr(3, 0, 8'h2C), 1'b0, '0);
    chk("R7 high word", lastData, 64'h11223344);
    access(1'b1, mkAddr(3, 0, 8'h3C), 1'b0, 64'hFFFFFFFFDEADBEEF);
    access(1'b0, mkAddr(3, 0, 8'h38), 1'b1, '0);
    chk("R7 wide read", lastData, 64'hDEADBEEF00000000);
  endtask

  task automatic tMisalign();
    access(1'b1, mkAddr(3, 0, 8'h24), 1'b1, 64'hFFFFFFFFFFFFFFFF);
    chk("R8 misaligned write err", 64'(lastErr), 64'h1);
    access(1'b0, mkAddr(3, 0, 8'h20), 1'b1, '0);
    chk("R8 mailbox untouched", lastData, 64'h0);
    chk("R9 legal access no err", 64'(lastErr), 64'h0);
    access(1'b0, mkAddr(3, 0, 8'h2A), 1'b0, '0);
    chk("R8 misaligned read err", 64'(lastErr), 64'h1);
    chk("R8 misaligned read zero", lastData, 64'h0);
    access(1'b1, mkAddr(0, 1, 8'h0C), 1'b1, 64'h0);
    access(1'b1, mkAddr(0, 1, 8'h0C), 1'b0, 64'h0);
    access(1'b1, mkAddr(0, 1, 8'h0C), 1'b1, 64'h0);
    chk("R8 misaligned wide lower err", 64'(lastErr), 64'h1);
    access(1'b1, mkAddr(0, 1, 8'h04), 1'b1, 64'h55);
    chk("R8 misaligned wide enable err", 64'(lastErr), 64'h1);
    access(1'b0, mkAddr(0, 1, 8'h04), 1'b0, '0);
    chk("R8 enable untouched", lastData, 64'h0);
  endtask

  task automatic tUnmapped();
    access(1'b0, mkAddr(2, 2, 8'h10), 1'b0, '0);
    chk("R9 unmapped read err", 64'(lastErr), 64'h1);
    chk("R9 unmapped read zero", lastData, 64'h0);
    access(1'b1, mkAddr(2, 2, 8'h40), 1'b0, 64'h77);
    chk("R9 unmapped write err", 64'(lastErr), 64'h1);
    chk("R9 unmapped write no irq", 64'(irqOut), 64'h0);
  endtask

  task automatic tTiming();
    access(1'b0, mkAddr(0, 0, 8'h00), 1'b0, '0);
    chk("R11 read valid", 64'(lastValid), 64'h1);
    @(posedge clk); #1;
    chk("R11 idle no valid", 64'(rspValid), 64'h0);
    access(1'b1, mkAddr(0, 0, 8'h04), 1'b0, 64'h9);
    chk("R11 write no valid", 64'(lastValid), 64'h0);
  endtask

  task automatic tIndependence();
    access(1'b1, mkAddr(1, 2, 8'h30) | (46'd1 << 20), 1'b0, 64'hCAFEF00D);
    access(1'b0, mkAddr(1, 2, 8'h30), 1'b0, '0);
    chk("R1 middle bits ignored", lastData, 64'hCAFEF00D);
    access(1'b0, mkAddr(0, 2, 8'h30), 1'b0, '0);
    chk("R12 core2 mailbox untouched", lastData, 64'h0);
    access(1'b0, mkAddr(3, 2, 8'h30), 1'b0, '0);
    chk("R12 core14 mailbox untouched", lastData, 64'h0);
    access(1'b1, mkAddr(2, 3, 8'h08), 1'b0, 64'h1);
    chk("R1 node2 core3 is id11", 64'(irqOut), 64'h0800);
    access(1'b0, mkAddr(2, 2, 8'h00), 1'b0, '0);
    chk("R12 neighbour pending untouched", lastData, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 irq during reset", 64'(irqOut), 64'h0);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tRaise();
    tLower();
    tWriteOnly();
    tEnable();
    tMailbox();
    tMisalign();
    tUnmapped();
    tTiming();
    tIndependence();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule